// File: doc/BRIEF.md
# Affine INT8 Quantizer and Dequantizer

This block converts signed fixed-point real values into 8-bit integer codes and converts codes back into real values, using a programmable clipping window, scale and zero-point. Real values on both sides are Q8.8 numbers in 16 bits. The forward path first clamps its input to the window. It then multiplies by a software-precomputed reciprocal of the scale, adds the zero-point, rounds and saturates to the code range of the selected mode. The reverse path removes the zero-point and multiplies by the scale, then rounds and saturates back into Q8.8.

Three modes share the hardware. Symmetric full-range uses codes -128..127. Symmetric restricted-range drops code -128, so that products of symmetric codes carry no bias. Asymmetric mode takes an arbitrary window and a zero-point, so that real zero lands exactly on an unsigned code. Each path is an independent valid/ready stream with a fixed two-register pipeline. The configuration inputs are static while traffic flows.

Top module: `qdq_int8`

## Requirements
- R1: While reset is asserted and right after it, `qo_valid` and `do_valid` are low and `qi_ready` and `di_ready` are high.
- R2: A quantizer input above the upper window limit is treated as the upper limit, and one below the lower limit as the lower limit, before scaling. The window is [`cfg_clip_lo`, `cfg_clip_hi`] in asymmetric mode and [-`cfg_clip_hi`, `cfg_clip_hi`] in symmetric modes.
- R3: The code is round(x * recip + z), where x is the clamped Q8.8 input, recip is `cfg_recip` read as unsigned Q8.16, z is the zero-point and rounding is half away from zero. Symmetric codes are two's complement in `qo_code`.
- R4: `cfg_mode` = 0 selects symmetric full range: results saturate to -128 (8'h80) and 127 (8'h7F).
- R5: `cfg_mode` = 1 selects symmetric restricted range: results saturate to -127 (8'h81) and 127, and 8'h80 never appears on `qo_code`.
- R6: `cfg_mode` = 2 or 3 selects asymmetric mode: z = `cfg_zero` (unsigned), codes are unsigned 0..255 with saturation at both ends, and a real input of 0 gives code z.
- R7: In the symmetric modes, `cfg_zero` and `cfg_clip_lo` have no effect on either path (z = 0).
- R8: The dequantizer outputs round((q - z) * scale) in Q8.8 with half-away-from-zero rounding, where `cfg_scale` is unsigned Q8.16 and q is read as signed in the symmetric modes and unsigned in asymmetric mode. The result saturates to 16'h8000..16'h7FFF.
- R9: A beat accepted at clock edge N appears on the output just after edge N+1, not after edge N. Back-to-back beats are accepted and delivered one per cycle.
- R10: While an output is valid and its ready is low, that output holds its value and stays valid. The input ready of the same path is low only in that situation. No beat is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 symmetric full, 1 symmetric restricted, 2/3 asymmetric |
| cfg_clip_lo | input | 16 | Lower clip limit, Q8.8 (asymmetric only) |
| cfg_clip_hi | input | 16 | Upper clip limit, Q8.8; symmetric half-width |
| cfg_zero | input | 8 | Zero-point code (asymmetric only) |
| cfg_recip | input | 24 | Reciprocal of the scale, unsigned Q8.16 |
| cfg_scale | input | 24 | Scale, unsigned Q8.16 |
| qi_valid | input | 1 | Quantizer input valid |
| qi_ready | output | 1 | Quantizer input ready |
| qi_real | input | 16 | Quantizer input, Q8.8 |
| qo_valid | output | 1 | Code output valid |
| qo_ready | input | 1 | Code output ready |
| qo_code | output | 8 | Quantized code |
| di_valid | input | 1 | Dequantizer input valid |
| di_ready | output | 1 | Dequantizer input ready |
| di_code | input | 8 | Code to dequantize |
| do_valid | output | 1 | Real output valid |
| do_ready | input | 1 | Real output ready |
| do_real | output | 16 | Dequantized value, Q8.8 |

## Verification
A wrong product or rounding in the first register stage shows on `qo_code` or `do_real` exactly one cycle after the accepting edge, as an off-by-one code near half-step inputs or a wrong saturation code. A corrupted valid bit shows as a beat that appears early, late, twice or not at all. Under back-pressure it shows as an output that changes while stalled or as a ready that drops without a stalled output, which is visible at once on the ready port.

// File: rtl/qdq_int8.sv
module qdq_int8 #(
  parameter int DW = 16,
  parameter int DF = 8,
  parameter int RW = 24,
  parameter int RF = 16,
  parameter int SW = 24,
  parameter int SF = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_mode,
  input  logic signed [DW-1:0] cfg_clip_lo,
  input  logic signed [DW-1:0] cfg_clip_hi,
  input  logic [7:0]           cfg_zero,
  input  logic [RW-1:0]        cfg_recip,
  input  logic [SW-1:0]        cfg_scale,
  input  logic                 qi_valid,
  output logic                 qi_ready,
  input  logic [DW-1:0]        qi_real,
  output logic                 qo_valid,
  input  logic                 qo_ready,
  output logic [7:0]           qo_code,
  input  logic                 di_valid,
  output logic                 di_ready,
  input  logic [7:0]           di_code,
  output logic                 do_valid,
  input  logic                 do_ready,
  output logic [DW-1:0]        do_real
);
  localparam int QPW = DW + RW + 1;
  localparam int QSW = QPW + 2;
  localparam int QSH = RF + DF;
  localparam int DPW = 10 + SW + 1;
  localparam int DSH = SF - DF;
  localparam logic signed [DPW-1:0] DMAX = (DPW'(1) <<< (DW-1)) - DPW'(1);
  localparam logic signed [DPW-1:0] DMIN = -(DPW'(1) <<< (DW-1));

  logic asym, rstr;
  logic [7:0] zp;
  assign asym = cfg_mode[1];
  assign rstr = (cfg_mode == 2'd1);
  assign zp   = asym ? cfg_zero : 8'd0;

  // quantize, stage 1: clamp and scale
  logic signed [DW-1:0]  lo, xin, xc;
  logic signed [QPW-1:0] q_prod;
  logic q_v1, q_en;
  assign lo  = asym ? cfg_clip_lo : -cfg_clip_hi;
  assign xin = $signed(qi_real);
  assign xc  = (xin > cfg_clip_hi) ? cfg_clip_hi : (xin < lo) ? lo : xin;
  assign q_en = !qo_valid || qo_ready;
  assign qi_ready = q_en;

  // quantize, stage 2: zero-point, round, saturate
  logic signed [QSW-1:0] qsum, qmag, qrnd, qint, qlo, qhi;
  logic [7:0] q_next;
  always_comb begin
    qsum = QSW'(q_prod) + (QSW'($signed({1'b0, zp})) <<< QSH);
    qmag = qsum[QSW-1] ? -qsum : qsum;
    qrnd = (qmag + (QSW'(1) <<< (QSH-1))) >>> QSH;
    qint = qsum[QSW-1] ? -qrnd : qrnd;
    qlo  = asym ? QSW'(0) : rstr ? QSW'(-127) : QSW'(-128);
    qhi  = asym ? QSW'(255) : QSW'(127);
    if (qint < qlo)      q_next = asym ? 8'h00 : rstr ? 8'h81 : 8'h80;
    else if (qint > qhi) q_next = asym ? 8'hFF : 8'h7F;
    else                 q_next = qint[7:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q_v1     <= 1'b0;
      qo_valid <= 1'b0;
    end else if (q_en) begin
      q_v1     <= qi_valid;
      qo_valid <= q_v1;
    end

  always_ff @(posedge clk)
    if (q_en) begin
      if (qi_valid) q_prod <= QPW'(xc) * QPW'($signed({1'b0, cfg_recip}));
      if (q_v1)     qo_code <= q_next;
    end

  // dequantize, stage 1: remove zero-point and scale
  logic signed [9:0] dz, diff;
  logic signed [DPW-1:0] d_prod, dmag, drnd, dint;
  logic d_v1, d_en;
  assign dz   = asym ? $signed({2'b00, di_code}) : $signed({{2{di_code[7]}}, di_code});
  assign diff = dz - $signed({2'b00, zp});
  assign d_en = !do_valid || do_ready;
  assign di_ready = d_en;

  // dequantize, stage 2: round to Q8.8 and saturate
  logic [DW-1:0] d_next;
  always_comb begin
    dmag = d_prod[DPW-1] ? -d_prod : d_prod;
    drnd = (dmag + (DPW'(1) <<< (DSH-1))) >>> DSH;
    dint = d_prod[DPW-1] ? -drnd : drnd;
    if (dint > DMAX)      d_next = {1'b0, {(DW-1){1'b1}}};
    else if (dint < DMIN) d_next = {1'b1, {(DW-1){1'b0}}};
    else                  d_next = dint[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      d_v1     <= 1'b0;
      do_valid <= 1'b0;
    end else if (d_en) begin
      d_v1     <= di_valid;
      do_valid <= d_v1;
    end

  always_ff @(posedge clk)
    if (d_en) begin
      if (di_valid) d_prod <= DPW'(diff) * DPW'($signed({1'b0, cfg_scale}));
      if (d_v1)     do_real <= d_next;
    end
endmodule

// File: rtl/qdq_int8_chk.sv
module qdq_int8_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_mode,
  input logic          qi_ready,
  input logic          qo_valid,
  input logic          qo_ready,
  input logic [7:0]    qo_code,
  input logic          di_ready,
  input logic          do_valid,
  input logic          do_ready,
  input logic [DW-1:0] do_real
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !qo_valid && !do_valid);

  assert_no_m128_R5: assert property (@(posedge clk) disable iff (!rst_n)
    qo_valid && cfg_mode == 2'd1 |-> qo_code != 8'h80);

  assert_q_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    qo_valid && !qo_ready |=> qo_valid && $stable(qo_code));

  assert_d_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    do_valid && !do_ready |=> do_valid && $stable(do_real));

  assert_q_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !qi_ready |-> qo_valid && !qo_ready);

  assert_d_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !di_ready |-> do_valid && !do_ready);
endmodule

bind qdq_int8 qdq_int8_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
  .qi_ready(qi_ready), .qo_valid(qo_valid), .qo_ready(qo_ready), .qo_code(qo_code),
  .di_ready(di_ready), .do_valid(do_valid), .do_ready(do_ready), .do_real(do_real)
);

// File: tb/qdq_int8_bench.sv
module qdq_int8_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [15:0] cfg_clip_lo = '0, cfg_clip_hi = '0;
  logic [7:0]  cfg_zero = '0;
  logic [23:0] cfg_recip = '0, cfg_scale = '0;
  logic qi_valid = 1'b0, qo_ready = 1'b1, di_valid = 1'b0, do_ready = 1'b1;
  logic [15:0] qi_real = '0;
  logic [7:0]  di_code = '0;
  logic qi_ready, qo_valid, di_ready, do_valid;
  logic [7:0]  qo_code;
  logic [15:0] do_real;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  qdq_int8 u_qdq_int8 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_clip_lo(cfg_clip_lo),
    .cfg_clip_hi(cfg_clip_hi), .cfg_zero(cfg_zero), .cfg_recip(cfg_recip),
    .cfg_scale(cfg_scale), .qi_valid(qi_valid), .qi_ready(qi_ready), .qi_real(qi_real),
    .qo_valid(qo_valid), .qo_ready(qo_ready), .qo_code(qo_code), .di_valid(di_valid),
    .di_ready(di_ready), .di_code(di_code), .do_valid(do_valid), .do_ready(do_ready),
    .do_real(do_real)
  );

  // {mode, clip_lo, clip_hi, zero, recip, x, expected code}
  localparam int NQ = 28;
  localparam logic [89:0] QV [0:NQ-1] = '{
    {2'd0, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'h0100, 8'h20},
    {2'd0, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'hFF00, 8'hE0},
    {2'd0, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'h0400, 8'h7F},
    {2'd0, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'hFC00, 8'h80},
    {2'd0, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'h0A00, 8'h7F},
    {2'd0, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'hF600, 8'h80},
    {2'd0, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'h0004, 8'h01},
    {2'd0, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'hFFFC, 8'hFF},
    {2'd0, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'h0003, 8'h00},
    {2'd0, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'h0000, 8'h00},
    {2'd1, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'hFC00, 8'h81},
    {2'd1, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'h0400, 8'h7F},
    {2'd1, 16'h0000, 16'h0400, 8'h00, 24'h200000, 16'h0100, 8'h20},
    {2'd1, 16'h0000, 16'h0400, 8'h30, 24'h200000, 16'h0000, 8'h00},
    {2'd1, 16'h0000, 16'h0400, 8'h30, 24'h200000, 16'hFF00, 8'hE0},
    {2'd0, 16'h0000, 16'h0400, 8'h30, 24'h200000, 16'h0100, 8'h20},
    {2'd2, 16'hFC00, 16'h0800, 8'h55, 24'h100000, 16'h0000, 8'h55},
    {2'd2, 16'hFC00, 16'h0800, 8'h55, 24'h100000, 16'h0100, 8'h65},
    {2'd2, 16'hFC00, 16'h0800, 8'h55, 24'h100000, 16'hFC00, 8'h15},
    {2'd2, 16'hFC00, 16'h0800, 8'h55, 24'h100000, 16'hF600, 8'h15},
    {2'd2, 16'hFC00, 16'h0800, 8'h55, 24'h100000, 16'h0800, 8'hD5},
    {2'd2, 16'hFC00, 16'h0800, 8'h55, 24'h100000, 16'h1400, 8'hD5},
    {2'd2, 16'hFC00, 16'h0800, 8'h55, 24'h100000, 16'h0004, 8'h55},
    {2'd2, 16'hFC00, 16'h0800, 8'h55, 24'h100000, 16'h0008, 8'h56},
    {2'd2, 16'hFC00, 16'h0800, 8'h55, 24'h100000, 16'hFFF8, 8'h55},
    {2'd3, 16'hFC00, 16'h0800, 8'h55, 24'h100000, 16'h0100, 8'h65},
    {2'd2, 16'hFC00, 16'h0800, 8'hC8, 24'h100000, 16'h0800, 8'hFF},
    {2'd2, 16'hFC00, 16'h0800, 8'h10, 24'h100000, 16'hFC00, 8'h00}
  };

  // {mode, zero, scale, code, expected real}
  localparam int ND = 13;
  localparam logic [57:0] DV [0:ND-1] = '{
    {2'd0, 8'h00, 24'h002000, 8'h20, 16'h0400},
    {2'd0, 8'h00, 24'h002000, 8'hE0, 16'hFC00},
    {2'd0, 8'h00, 24'h002000, 8'h80, 16'hF000},
    {2'd2, 8'h55, 24'h002000, 8'h55, 16'h0000},
    {2'd2, 8'h55, 24'h002000, 8'hFF, 16'h1540},
    {2'd2, 8'h55, 24'h002000, 8'h00, 16'hF560},
    {2'd0, 8'h55, 24'h002000, 8'h20, 16'h0400},
    {2'd0, 8'h00, 24'h000080, 8'h01, 16'h0001},
    {2'd0, 8'h00, 24'h000080, 8'hFF, 16'hFFFF},
    {2'd0, 8'h00, 24'h00007F, 8'h01, 16'h0000},
    {2'd0, 8'h00, 24'hFF0000, 8'h7F, 16'h7FFF},
    {2'd0, 8'h00, 24'hFF0000, 8'h80, 16'h8000},
    {2'd1, 8'h00, 24'h002000, 8'h81, 16'hF020}
  };

  function automatic string qtag(int i);
    case (i)
      4, 5, 19, 21:           return "R2";
      2, 3:                   return "R4";
      10, 11:                 return "R5";
      13, 14, 15:             return "R7";
      16, 17, 18, 20, 25, 26, 27: return "R6";
      default:                return "R3";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_q(input logic [89:0] v, input string req);
    @(negedge clk);
    cfg_mode = v[89:88]; cfg_clip_lo = v[87:72]; cfg_clip_hi = v[71:56];
    cfg_zero = v[55:48]; cfg_recip = v[47:24]; qi_real = v[23:8];
    qi_valid = 1'b1; qo_ready = 1'b1;
    @(negedge clk);
    qi_valid = 1'b0;
    chk(!qo_valid, "R9", "quant output too early", 32'(qo_valid), 32'd0);
    @(negedge clk);
    chk(qo_valid && qo_code == v[7:0], req, "quant code", 32'(qo_code), 32'(v[7:0]));
  endtask

  task automatic run_d(input logic [57:0] v, input string req);
    @(negedge clk);
    cfg_mode = v[57:56]; cfg_zero = v[55:48]; cfg_scale = v[47:24]; di_code = v[23:16];
    di_valid = 1'b1; do_ready = 1'b1;
    @(negedge clk);
    di_valid = 1'b0;
    chk(!do_valid, "R9", "dequant output too early", 32'(do_valid), 32'd0);
    @(negedge clk);
    chk(do_valid && do_real == v[15:0], req, "dequant real", 32'(do_real), 32'(v[15:0]));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!qo_valid && !do_valid && qi_ready && di_ready, "R1", "in reset",
        {28'd0, qo_valid, do_valid, qi_ready, di_ready}, 32'h3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!qo_valid && !do_valid && qi_ready && di_ready, "R1", "after reset",
        {28'd0, qo_valid, do_valid, qi_ready, di_ready}, 32'h3);

    for (int i = 0; i < NQ; i++) run_q(QV[i], qtag(i));
    for (int i = 0; i < ND; i++) run_d(DV[i], (i == 6) ? "R7" : "R8");

    // R10 back-pressure and R9 back-to-back delivery on the quantizer
    @(negedge clk);
    cfg_mode = 2'd0; cfg_clip_hi = 16'h0400; cfg_zero = 8'h00; cfg_recip = 24'h200000;
    qo_ready = 1'b0; qi_valid = 1'b1; qi_real = 16'h0100;
    @(negedge clk);
    qi_real = 16'hFF00;
    @(negedge clk);
    qi_real = 16'h0004;
    chk(!qi_ready, "R10", "ready while stalled", 32'(qi_ready), 32'd0);
    chk(qo_valid && qo_code == 8'h20, "R10", "first held code", 32'(qo_code), 32'h20);
    @(negedge clk);
    chk(qo_valid && qo_code == 8'h20, "R10", "code held", 32'(qo_code), 32'h20);
    qo_ready = 1'b1;
    @(negedge clk);
    qi_valid = 1'b0;
    chk(qo_valid && qo_code == 8'hE0, "R10", "second code", 32'(qo_code), 32'hE0);
    @(negedge clk);
    chk(qo_valid && qo_code == 8'h01, "R9", "third code next cycle", 32'(qo_code), 32'h01);
    @(negedge clk);
    chk(!qo_valid, "R10", "no extra beat", 32'(qo_valid), 32'd0);

    // R10 on the dequantizer
    @(negedge clk);
    cfg_scale = 24'h002000; do_ready = 1'b0; di_valid = 1'b1; di_code = 8'h20;
    @(negedge clk);
    di_code = 8'hE0;
    @(negedge clk);
    di_valid = 1'b0;
    chk(!di_ready && do_valid && do_real == 16'h0400, "R10", "dequant stall",
        32'(do_real), 32'h0400);
    @(negedge clk);
    do_ready = 1'b1;
    @(negedge clk);
    chk(do_valid && do_real == 16'hFC00, "R10", "dequant drain", 32'(do_real), 32'hFC00);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule